// File: doc/BRIEF.md
# Packed Unsigned Saturating Left Shifter

The block shifts every unsigned lane of a 128-bit packed operand left by a fixed amount. It clamps each lane whose shifted value does not fit in its width, instead of letting the high bits wrap. One 7-bit immediate gives both the lane width and the shift amount. The immediate arrives as a 4-bit high part and a 3-bit low part. A scalar/vector select and a 64/128-bit select set how many lanes take part.

Results come out one cycle after `validIn` with `validOut`. A registered flag reports encodings that cannot be executed. A sticky flag records that at least one lane was clamped since the flag was last cleared. The flag is cleared only by reset or by `satClear`.

Top module: `packed_usat_shl`

## Requirements
- R1: The lane width is 8 << k, where k is the index of the highest set bit of `immHi`. `immHi` = 0001 gives 8 bits, 001x gives 16, 01xx gives 32 and 1xxx gives 64.
- R2: The shift amount is the unsigned value of {`immHi`,`immLo`} minus the lane width, so it lies between 0 and lane width − 1.
- R3: An operation with `immHi` = 0000 sets `illegalOut`. It leaves `resOut` at its previous value and does not change `satSticky`.
- R4: In vector mode (`scalarMode` = 0), the datasize is 128 bits when `wideMode` = 1 and 64 bits when `wideMode` = 0. The number of lanes is the datasize divided by the lane width, and lane e occupies bits [e·w+w−1 : e·w].
- R5: In vector mode, a 64-bit lane width with `wideMode` = 0 sets `illegalOut` and is handled like R3.
- R6: In scalar mode, only lane 0 is processed, and the datasize equals the lane width. `wideMode` has no effect in scalar mode.
- R7: Each active lane is treated as unsigned and shifted left with no rounding. If the exact shifted value exceeds the lane maximum, the lane result is all ones.
- R8: A legal operation in which any active lane clamps sets `satSticky` to 1. No operation ever clears it.
- R9: `satSticky` is cleared by the active-low asynchronous reset and by `satClear` on a clock edge. If `satClear` and a clamping operation arrive in the same cycle, the flag ends at 1.
- R10: Result bits above the active datasize are 0.
- R11: `validOut` follows `validIn` one cycle later. `resOut` and `illegalOut` change only on the edge after a cycle with `validIn` = 1, and hold otherwise. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Operation presented this cycle |
| scalarMode | input | 1 | 1: single lane; 0: packed vector |
| wideMode | input | 1 | Vector datasize select: 1 = 128 bits, 0 = 64 bits |
| immHi | input | 4 | High part of the shift immediate |
| immLo | input | 3 | Low part of the shift immediate |
| opIn | input | 128 | Packed operand |
| satClear | input | 1 | Synchronous clear of the sticky flag |
| validOut | output | 1 | Result valid, one cycle after validIn |
| resOut | output | 128 | Registered packed result |
| illegalOut | output | 1 | Registered illegal-encoding flag |
| satSticky | output | 1 | Cumulative saturation flag |

## Verification
The bench drives shifts of 0 and lane width − 1 for every lane width, because an off-by-one in the shift decode would either clamp lanes that fit or let a lane wrap silently. It runs 64-bit vector mode and scalar mode over random operands. A design that forgets to mask the upper half or the unused lanes would leave stray non-zero bits there and could set the sticky flag from a lane that is not active. Both illegal encodings are sent after a known result, to catch a design that overwrites the result or touches the sticky flag. A clear arrives in the same cycle as a clamping operation, to catch a design that gives the clear priority.

// File: rtl/usat_shl_pkg.sv
package usat_shl_pkg;
  localparam int DATA_W     = 128;
  localparam int IMM_HI_W   = 4;
  localparam int IMM_LO_W   = 3;
  localparam int BASE_W     = 8;
  localparam int NUM_WIDTHS = IMM_HI_W;
  localparam int BYTES      = DATA_W / 8;
  localparam int HALF_BYTES = BYTES / 2;
  localparam int SHIFT_W    = $clog2(BASE_W << (NUM_WIDTHS - 1));

  typedef struct packed {
    logic                  load;
    logic                  illegal;
    logic [NUM_WIDTHS-1:0] widthSel;
    logic [SHIFT_W-1:0]    shiftAmt;
    logic [BYTES-1:0]      byteEn;
  } strobe_t;
endpackage

// File: rtl/usat_shl_ctrl.sv
module usat_shl_ctrl
  import usat_shl_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                validIn,
  input  logic                scalarMode,
  input  logic                wideMode,
  input  logic [IMM_HI_W-1:0] immHi,
  input  logic [IMM_LO_W-1:0] immLo,
  input  logic                satClear,
  input  logic                anySat,
  output strobe_t             strb,
  output logic                validOut,
  output logic                illegalOut,
  output logic                satSticky
);
  localparam int IMM_W = IMM_HI_W + IMM_LO_W;

  logic [$clog2(NUM_WIDTHS)-1:0] widthIdx;
  logic [IMM_W-1:0]              laneW;
  logic [IMM_W-1:0]              immVal;
  logic [IMM_W-1:0]              shiftFull;
  logic [BYTES:0]                dsBytes;
  logic                          badEnc;

  always_comb begin
    widthIdx = '0;
    for (int i = 0; i < NUM_WIDTHS; i++)
      if (immHi[i]) widthIdx = i[$clog2(NUM_WIDTHS)-1:0];
    laneW     = IMM_W'(BASE_W) << widthIdx;
    immVal    = {immHi, immLo};
    shiftFull = immVal - laneW;
    badEnc    = (immHi == '0) ||
                (!scalarMode && !wideMode && immHi[IMM_HI_W-1]);
    if (scalarMode)    dsBytes = (BYTES+1)'(laneW >> 3);
    else if (wideMode) dsBytes = (BYTES+1)'(BYTES);
    else               dsBytes = (BYTES+1)'(HALF_BYTES);
    strb.load     = validIn;
    strb.illegal  = badEnc;
    strb.widthSel = NUM_WIDTHS'(1) << widthIdx;
    strb.shiftAmt = shiftFull[SHIFT_W-1:0];
    strb.byteEn   = BYTES'(((BYTES+1)'(1) << dsBytes) - (BYTES+1)'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validOut   <= 1'b0;
      illegalOut <= 1'b0;
      satSticky  <= 1'b0;
    end else begin
      validOut <= validIn;
      if (validIn) illegalOut <= badEnc;
      satSticky <= (satSticky & ~satClear) | (validIn & ~badEnc & anySat);
    end
  end

  assert_latency_R11: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);
  assert_zero_hi_R3: assert property (@(posedge clk) disable iff (!rstN)
    validIn && immHi == '0 |=> illegalOut);
  assert_narrow_vec_R5: assert property (@(posedge clk) disable iff (!rstN)
    validIn && !scalarMode && !wideMode && immHi[IMM_HI_W-1] |=> illegalOut);
  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    satSticky && !satClear |=> satSticky);
  assert_sticky_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    validIn && !badEnc && anySat |=> satSticky);
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    satClear && !(validIn && anySat) |=> !satSticky);
endmodule

// File: rtl/usat_shl_dp.sv
module usat_shl_dp
  import usat_shl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opIn,
  input  strobe_t           strb,
  output logic              anySat,
  output logic [DATA_W-1:0] resOut
);
  logic [NUM_WIDTHS-1:0][DATA_W-1:0] candRes;
  logic [NUM_WIDTHS-1:0]             candSat;
  logic [DATA_W-1:0]                 nextRes;

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : gWidth
    localparam int LW = BASE_W << g;
    localparam int NL = DATA_W / LW;
    logic [NL-1:0] laneSat;
    for (genvar l = 0; l < NL; l++) begin : gLane
      logic [LW-1:0] laneIn, keepMask, laneOut;
      logic          laneActive, overflow;
      assign laneIn     = opIn[l*LW +: LW];
      assign keepMask   = {LW{1'b1}} >> strb.shiftAmt;
      assign overflow   = |(laneIn & ~keepMask);
      assign laneActive = strb.byteEn[l*LW/8];
      assign laneOut    = overflow ? {LW{1'b1}} : (laneIn << strb.shiftAmt);
      assign candRes[g][l*LW +: LW] = laneOut & {LW{laneActive}};
      assign laneSat[l] = overflow & laneActive;
    end
    assign candSat[g] = |laneSat;
  end

  always_comb begin
    nextRes = '0;
    for (int g = 0; g < NUM_WIDTHS; g++)
      if (strb.widthSel[g]) nextRes = nextRes | candRes[g];
  end
  assign anySat = |(candSat & strb.widthSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resOut <= '0;
    else if (strb.load && !strb.illegal) resOut <= nextRes;
  end

  assert_illegal_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.load && strb.illegal |=> $stable(resOut));
  assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.load && !strb.illegal && !strb.byteEn[HALF_BYTES]
      |=> resOut[DATA_W-1:DATA_W/2] == '0);
endmodule

// File: rtl/packed_usat_shl.sv
module packed_usat_shl
  import usat_shl_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                validIn,
  input  logic                scalarMode,
  input  logic                wideMode,
  input  logic [IMM_HI_W-1:0] immHi,
  input  logic [IMM_LO_W-1:0] immLo,
  input  logic [DATA_W-1:0]   opIn,
  input  logic                satClear,
  output logic                validOut,
  output logic [DATA_W-1:0]   resOut,
  output logic                illegalOut,
  output logic                satSticky
);
  strobe_t strb;
  logic    anySat;

  usat_shl_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .validIn(validIn), .scalarMode(scalarMode),
    .wideMode(wideMode), .immHi(immHi), .immLo(immLo), .satClear(satClear),
    .anySat(anySat), .strb(strb), .validOut(validOut),
    .illegalOut(illegalOut), .satSticky(satSticky)
  );

  usat_shl_dp dp_i (
    .clk(clk), .rstN(rstN), .opIn(opIn), .strb(strb),
    .anySat(anySat), .resOut(resOut)
  );
endmodule

// File: tb/packed_usat_shl_tb_top.sv
module packed_usat_shl_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         validIn = 1'b0, scalarMode = 1'b0, wideMode = 1'b0, satClear = 1'b0;
  logic [3:0]   immHi = '0;
  logic [2:0]   immLo = '0;
  logic [127:0] opIn = '0;
  logic         validOut, illegalOut, satSticky;
  logic [127:0] resOut;

  logic         expValid = 0, expIll = 0, expSticky = 0;
  logic [127:0] expRes = '0;
  int           total = 0, bad = 0;
  bit           checking = 0, finished = 0;
  string        curReq = "R11";

  always #2 clk = ~clk;

  packed_usat_shl dut_i (
    .clk(clk), .rstN(rstN), .validIn(validIn), .scalarMode(scalarMode),
    .wideMode(wideMode), .immHi(immHi), .immLo(immLo), .opIn(opIn),
    .satClear(satClear), .validOut(validOut), .resOut(resOut),
    .illegalOut(illegalOut), .satSticky(satSticky)
  );

  function automatic void model(input logic [127:0] op, input logic [3:0] hi,
      input logic [2:0] lo, input logic sc, input logic wd,
      output logic [127:0] res, output logic ill, output logic sat);
    int esize, ds, sh;
    logic [127:0] maskW, lane, v;
    esize = hi[3] ? 64 : hi[2] ? 32 : hi[1] ? 16 : 8;
    ill = (hi == 0) || (!sc && !wd && esize == 64);
    ds = sc ? esize : (wd ? 128 : 64);
    sh = int'({hi, lo}) - esize;
    maskW = (128'd1 << esize) - 128'd1;
    res = '0; sat = 0;
    if (!ill)
      for (int e = 0; e < ds / esize; e++) begin
        lane = (op >> (e * esize)) & maskW;
        v = lane << sh;
        if (v > maskW) begin v = maskW; sat = 1; end
        res = res | (v << (e * esize));
      end
  endfunction

  always @(posedge clk or negedge rstN) begin
    logic [127:0] r; logic il, st;
    if (!rstN) begin
      expValid <= 0; expIll <= 0; expSticky <= 0; expRes <= '0;
    end else begin
      model(opIn, immHi, immLo, scalarMode, wideMode, r, il, st);
      expValid <= validIn;
      if (validIn) begin
        expIll <= il;
        if (!il) expRes <= r;
      end
      expSticky <= (expSticky && !satClear) || (validIn && !il && st);
    end
  end

  task automatic chk(input string what, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) if (checking && !finished) begin
    chk("validOut", 128'(validOut), 128'(expValid));
    chk("resOut", resOut, expRes);
    chk("illegalOut", 128'(illegalOut), 128'(expIll));
    chk("satSticky", 128'(satSticky), 128'(expSticky));
  end

  task automatic op(input logic [127:0] o, input logic [3:0] hi, input logic [2:0] lo,
                    input logic sc, input logic wd, input logic clr = 0, input logic v = 1);
    opIn = o; immHi = hi; immLo = lo; scalarMode = sc; wideMode = wd;
    satClear = clr; validIn = v;
    @(negedge clk);
    validIn = 0; satClear = 0;
  endtask

  function automatic logic [127:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic sweep(input logic [3:0] hi, input logic sc, input logic wd);
    for (int lo = 0; lo < 8; lo++) begin
      op(rnd(), hi, 3'(lo), sc, wd);
      op(rnd() >> ($urandom % 128), hi | 4'($urandom % 2), 3'(lo), sc, wd);
    end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      finished = 1; total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    checking = 1;
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 R2: every lane width, shifts 0 and max, scalar
    curReq = "R1";
    op(128'hff, 4'b0001, 3'd0, 1, 0);
    op(128'h1, 4'b0001, 3'd7, 1, 0);
    op(128'h8000, 4'b0011, 3'd7, 1, 0);
    op(128'h1, 4'b1111, 3'd7, 1, 0);
    curReq = "R2";
    for (int h = 1; h < 16; h++) sweep(4'(h), 1, 1);
    // R4 R10: vector 128 and 64
    curReq = "R4";
    for (int h = 1; h < 16; h++) sweep(4'(h), 0, 1);
    curReq = "R10";
    for (int h = 1; h < 8; h++) sweep(4'(h), 0, 0);
    // R6: scalar ignores wideMode and upper lanes
    curReq = "R6";
    for (int h = 1; h < 16; h++) sweep(4'(h), 1, 0);
    // R7: all-ones and boundary values
    curReq = "R7";
    op('1, 4'b0001, 3'd1, 0, 1);
    op({16{8'h7f}}, 4'b0001, 3'd1, 0, 1);
    op({8{16'h0001}}, 4'b0011, 3'd7, 0, 1);
    op({2{64'h0000_0000_ffff_ffff}}, 4'b1010, 3'd0, 0, 1);
    // R9: clear, then clear together with clamp
    curReq = "R9";
    op('0, 4'b0001, 3'd0, 0, 1, 1);
    op('0, 4'b0001, 3'd0, 0, 1, 0, 0);
    op('1, 4'b0010, 3'd3, 0, 1, 1);
    // R8: non-clamping ops keep flag set
    curReq = "R8";
    op(128'h1, 4'b0001, 3'd0, 0, 1);
    op('0, 4'b1000, 3'd0, 1, 0);
    op('0, 4'b0001, 3'd0, 0, 1, 1, 0);
    // R3: zero high part holds result and sticky
    curReq = "R3";
    op({16{8'h01}}, 4'b0001, 3'd1, 0, 1);
    op('1, 4'b0000, 3'd7, 0, 1);
    op('1, 4'b0000, 3'd2, 1, 0);
    // R5: 64-bit lanes in 64-bit vector
    curReq = "R5";
    op('1, 4'b1000, 3'd5, 0, 0);
    op('1, 4'b1100, 3'd0, 0, 1);
    op('1, 4'b1001, 3'd1, 0, 0);
    // R11: gaps in validIn hold outputs
    curReq = "R11";
    op(rnd(), 4'b0101, 3'd2, 0, 1, 0, 0);
    op(rnd(), 4'b0101, 3'd2, 0, 1);
    op(rnd(), 4'b0110, 3'd4, 0, 1, 0, 0);
    @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule